// File: doc/BRIEF.md
# Packet-Chain OTP Read Controller

This block puts a small 32-bit register window in front of a one-time-programmable word array. The array content is a chain of variable-length packets. Each packet is one header word followed by a payload whose length is coded in the header. Software does not read the array by address. It writes a word address into the mode register and sets the start bit in the control register. The controller then walks the chain from word 0 to find the packet whose span holds that address and copies that packet into a local buffer. Afterwards the header word can be read from a dedicated register, and the payload can be read through a data register that advances on every read.

The walk uses a synchronous-read array port with one cycle of latency. A status bit stays high for the whole lookup and buffer fill. An address beyond the last valid packet loads nothing: the header register then reads zero and the status bit still drops, so a polling loop always ends.

Top module: `otp_pkt_reader`

## Requirements
- R1: After reset the status busy bit (status register 0x0C, bit 6), the header register (0x20), the payload index register (0x08) and the mode register (0x04) all read zero.
- R2: Writing control (0x00) with bit 6 set starts a load using the word address held in mode bits 31:16. Busy reads 1 from the cycle after that write until the load completes. Control always reads back zero.
- R3: The first packet starts at word 0. Header bits 15:8 hold a length field f, and the packet spans f+2 words. Any requested address inside a packet's span loads that packet, and register 0x20 then returns its full header word.
- R4: A write to the index register (0x08) sets the payload index. Each read of the data register (0x24) returns the payload word at the current index and advances the index by one. A packet with field f has f+1 payload words, taken from the array words directly after its header.
- R5: A read of the data register at an index at or beyond the payload length returns zero and leaves the index unchanged, with no wrap.
- R6: A header with length field 0 ends the chain. A request at or beyond it loads no packet: the header reads 0, data reads return 0, and busy clears.
- R7: A start command written while busy is ignored. The running load completes with the packet for the address captured at the original start.
- R8: Every array read addresses a word below the array depth (2816 words). A chain that runs to the end of the array without a terminator ends the walk, and busy clears.
- R9: The mode register reads back the last value written. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a data-register read advances the index) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the same cycle as reg_rd |
| otp_rd_en | output | 1 | Array read request |
| otp_addr | output | 12 | Array word address |
| otp_rdata | input | 32 | Array read data, valid one cycle after the request |

## Verification
On every cycle the assertions check four things: busy rises after an accepted start; a start issued while busy leaves the captured address untouched; array addresses stay below the depth; and the index either steps by one or holds at the payload end. They also check that, once idle, the loaded payload length agrees with the length field of the published header, and that a failed lookup publishes a zero header. The mapping from address to packet, the payload values and their order, and the terminator and end-of-array outcomes depend on the array content, so only the bench scenarios can show them. Those scenarios use two array images: a short terminated chain and a chain that fills the array exactly.

// File: rtl/otp_pkt_pkg.sv
package otp_pkt_pkg;
    localparam int DATA_W = 32;
    localparam int REQ_W  = 16;
    localparam int LEN_W  = 8;
    localparam int LEN_LSB = 8;
    localparam int MODE_ADDR_LSB = 16;
    localparam int START_BIT = 6;
    localparam int BUSY_BIT  = 6;
    localparam int MAX_PAY = 1 << LEN_W;
    localparam int CNT_W   = $clog2(MAX_PAY + 1);

    localparam logic [7:0] OFF_CTRL = 8'h00;
    localparam logic [7:0] OFF_MODE = 8'h04;
    localparam logic [7:0] OFF_IDX  = 8'h08;
    localparam logic [7:0] OFF_STAT = 8'h0C;
    localparam logic [7:0] OFF_HDR  = 8'h20;
    localparam logic [7:0] OFF_DATA = 8'h24;

    typedef enum logic [1:0] {
        W_IDLE,
        W_HDR_REQ,
        W_HDR_CHK,
        W_PAYLOAD
    } walk_state_e;

    function automatic logic [LEN_W-1:0] hdr_len_field(input logic [DATA_W-1:0] w);
        return w[LEN_LSB +: LEN_W];
    endfunction
endpackage

// File: rtl/otp_pkt_buffer.sv
module otp_pkt_buffer
    import otp_pkt_pkg::*;
(
    input  logic              clk,
    input  logic              wr_en,
    input  logic [LEN_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LEN_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] store [MAX_PAY];

    always_ff @(posedge clk) begin
        if (wr_en) store[wr_idx] <= wr_data;
    end

    assign rd_data = store[rd_idx];
endmodule

// File: rtl/otp_pkt_walker.sv
module otp_pkt_walker
    import otp_pkt_pkg::*;
#(
    parameter int DEPTH  = 2816,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [REQ_W-1:0]  req_addr,
    output logic              otp_rd_en,
    output logic [ADDR_W-1:0] otp_addr,
    input  logic [DATA_W-1:0] otp_rdata,
    output logic              busy,
    output logic [DATA_W-1:0] hdr_word,
    output logic [CNT_W-1:0]  pay_cnt,
    output logic              buf_wr_en,
    output logic [LEN_W-1:0]  buf_wr_idx,
    output logic [DATA_W-1:0] buf_wr_data
);
    localparam int PTR_W = REQ_W + 1;
    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

    walk_state_e       state;
    logic [PTR_W-1:0]  ptr;
    logic [REQ_W-1:0]  req_q;
    logic [LEN_W-1:0]  len_q;
    logic [CNT_W-1:0]  iss_cnt;
    logic              cap_vld;
    logic              cap_rng;
    logic [LEN_W-1:0]  cap_idx;
    logic [DATA_W-1:0] hdr_q;
    logic [CNT_W-1:0]  cnt_q;

    logic [LEN_W-1:0]  f_now;
    logic [PTR_W-1:0]  nxt_ptr;
    logic [PTR_W-1:0]  pay_addr;
    logic              issuing;
    logic              pay_in_rng;

    assign f_now      = hdr_len_field(otp_rdata);
    assign nxt_ptr    = ptr + PTR_W'(f_now) + PTR_W'(2);
    assign pay_addr   = ptr + PTR_W'(1) + PTR_W'(iss_cnt);
    assign issuing    = (state == W_PAYLOAD) && (iss_cnt <= CNT_W'(len_q));
    assign pay_in_rng = pay_addr < DEPTH_P;

    always_comb begin
        otp_rd_en = 1'b0;
        otp_addr  = '0;
        if (state == W_HDR_REQ) begin
            otp_rd_en = 1'b1;
            otp_addr  = ptr[ADDR_W-1:0];
        end else if (issuing && pay_in_rng) begin
            otp_rd_en = 1'b1;
            otp_addr  = pay_addr[ADDR_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= W_IDLE;
            ptr     <= '0;
            req_q   <= '0;
            len_q   <= '0;
            iss_cnt <= '0;
            cap_vld <= 1'b0;
            cap_rng <= 1'b0;
            cap_idx <= '0;
            hdr_q   <= '0;
            cnt_q   <= '0;
        end else begin
            cap_vld <= issuing;
            cap_rng <= pay_in_rng;
            cap_idx <= iss_cnt[LEN_W-1:0];
            case (state)
                W_IDLE: begin
                    if (start) begin
                        req_q <= req_addr;
                        ptr   <= '0;
                        hdr_q <= '0;
                        cnt_q <= '0;
                        state <= W_HDR_REQ;
                    end
                end
                W_HDR_REQ: state <= W_HDR_CHK;
                W_HDR_CHK: begin
                    if (f_now == '0) begin
                        state <= W_IDLE;
                    end else if ({1'b0, req_q} < nxt_ptr) begin
                        hdr_q   <= otp_rdata;
                        len_q   <= f_now;
                        iss_cnt <= '0;
                        state   <= W_PAYLOAD;
                    end else begin
                        ptr   <= nxt_ptr;
                        state <= (nxt_ptr >= DEPTH_P) ? W_IDLE : W_HDR_REQ;
                    end
                end
                W_PAYLOAD: begin
                    if (issuing) iss_cnt <= iss_cnt + CNT_W'(1);
                    if (cap_vld && cap_idx == len_q) begin
                        cnt_q <= CNT_W'(len_q) + CNT_W'(1);
                        state <= W_IDLE;
                    end
                end
                default: state <= W_IDLE;
            endcase
        end
    end

    assign busy        = (state != W_IDLE);
    assign hdr_word    = hdr_q;
    assign pay_cnt     = cnt_q;
    assign buf_wr_en   = cap_vld;
    assign buf_wr_idx  = cap_idx;
    assign buf_wr_data = cap_rng ? otp_rdata : '0;

    a_r2_busy_after_start: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    a_r7_start_ignored_busy: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> $stable(req_q));

    a_r8_addr_in_array: assert property (@(posedge clk) disable iff (rst)
        otp_rd_en |-> (int'(otp_addr) < DEPTH));

    a_r6_missing_hdr_zero: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && pay_cnt == '0) |-> (hdr_word == '0));

    a_r3_len_matches_hdr: assert property (@(posedge clk) disable iff (rst)
        (!busy && pay_cnt != '0) |-> (pay_cnt == CNT_W'(hdr_len_field(hdr_word)) + CNT_W'(1)));
endmodule

// File: rtl/otp_pkt_regs.sv
module otp_pkt_regs
    import otp_pkt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              start,
    output logic [REQ_W-1:0]  req_addr,
    input  logic              busy,
    input  logic [DATA_W-1:0] hdr_word,
    input  logic [CNT_W-1:0]  pay_cnt,
    output logic [LEN_W-1:0]  rd_idx,
    input  logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mode_q;
    logic [CNT_W-1:0]  idx_q;
    logic              data_rd;
    logic              idx_live;

    assign start    = reg_wr && (reg_addr == OFF_CTRL) && reg_wdata[START_BIT];
    assign req_addr = mode_q[MODE_ADDR_LSB +: REQ_W];
    assign data_rd  = reg_rd && (reg_addr == OFF_DATA);
    assign idx_live = idx_q < pay_cnt;
    assign rd_idx   = idx_q[LEN_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            idx_q  <= '0;
        end else begin
            if (reg_wr && reg_addr == OFF_MODE) mode_q <= reg_wdata;
            if (data_rd && idx_live) idx_q <= idx_q + CNT_W'(1);
            if (reg_wr && reg_addr == OFF_IDX) idx_q <= reg_wdata[CNT_W-1:0];
            if (start && !busy) idx_q <= '0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_MODE: reg_rdata = mode_q;
            OFF_IDX:  reg_rdata = DATA_W'(idx_q);
            OFF_STAT: reg_rdata[BUSY_BIT] = busy;
            OFF_HDR:  reg_rdata = hdr_word;
            OFF_DATA: reg_rdata = idx_live ? rd_data : '0;
            default:  reg_rdata = '0;
        endcase
    end

    a_r4_idx_step: assert property (@(posedge clk) disable iff (rst)
        (data_rd && idx_live && !reg_wr) |=> (idx_q == $past(idx_q) + CNT_W'(1)));

    a_r5_idx_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !idx_live && !reg_wr) |=> $stable(idx_q));
endmodule

// File: rtl/otp_pkt_reader.sv
module otp_pkt_reader
    import otp_pkt_pkg::*;
#(
    parameter int DEPTH  = 2816,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              otp_rd_en,
    output logic [ADDR_W-1:0] otp_addr,
    input  logic [31:0]       otp_rdata
);
    logic              start;
    logic [REQ_W-1:0]  req_addr;
    logic              busy;
    logic [DATA_W-1:0] hdr_word;
    logic [CNT_W-1:0]  pay_cnt;
    logic              buf_wr_en;
    logic [LEN_W-1:0]  buf_wr_idx;
    logic [DATA_W-1:0] buf_wr_data;
    logic [LEN_W-1:0]  rd_idx;
    logic [DATA_W-1:0] rd_data;

    otp_pkt_regs u_regs (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .start(start), .req_addr(req_addr), .busy(busy),
        .hdr_word(hdr_word), .pay_cnt(pay_cnt),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

    otp_pkt_walker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_walk (
        .clk(clk), .rst(rst),
        .start(start), .req_addr(req_addr),
        .otp_rd_en(otp_rd_en), .otp_addr(otp_addr), .otp_rdata(otp_rdata),
        .busy(busy), .hdr_word(hdr_word), .pay_cnt(pay_cnt),
        .buf_wr_en(buf_wr_en), .buf_wr_idx(buf_wr_idx), .buf_wr_data(buf_wr_data)
    );

    otp_pkt_buffer u_buf (
        .clk(clk),
        .wr_en(buf_wr_en), .wr_idx(buf_wr_idx), .wr_data(buf_wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );
endmodule

// File: tb/sim_otp_pkt_reader.sv
module sim_otp_pkt_reader;
    localparam int DEPTH = 2816;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        otp_rd_en;
    logic [11:0] otp_addr;
    logic [31:0] otp_rdata = '0;

    logic [31:0] mem [0:DEPTH-1];
    int checks = 0;
    int errors = 0;
    int oob = 0;

    always #5 clk = ~clk;

    otp_pkt_reader u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .otp_rd_en(otp_rd_en), .otp_addr(otp_addr), .otp_rdata(otp_rdata)
    );

    always @(posedge clk) begin
        if (otp_rd_en) begin
            if (int'(otp_addr) >= DEPTH) oob++;
            else otp_rdata <= mem[otp_addr];
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic logic [31:0] hdr_val(input int id, input int f);
        return {16'h5A00 | 16'(id), 8'(f), 8'h3C};
    endfunction

    task automatic put_pkt(input int base, input int f, input int id);
        mem[base] = hdr_val(id, f);
        for (int k = 0; k <= f; k++) mem[base + 1 + k] = 32'hD000_0000 | 32'(base + 1 + k);
    endtask

    task automatic clear_mem();
        for (int i = 0; i < DEPTH; i++) mem[i] = 32'h0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            rd(8'h0C, s);
            if (s[6] == 1'b0) return;
        end
        chk("R2 busy never cleared", s, 32'h0);
    endtask

    task automatic start_load(input int addr);
        logic [31:0] s;
        wr(8'h04, 32'(addr) << 16);
        wr(8'h00, 32'h40);
        rd(8'h0C, s);
        chk("R2 busy after start", s & 32'h40, 32'h40);
        rd(8'h00, s);
        chk("R2 control reads zero", s, 32'h0);
        wait_idle();
    endtask

    task automatic t_found(input int addr, input int base, input int f, input int id, input bit full);
        logic [31:0] d;
        start_load(addr);
        rd(8'h20, d);
        chk("R3 header of containing packet", d, hdr_val(id, f));
        wr(8'h08, 32'h0);
        for (int k = 0; k <= f; k++) begin
            rd(8'h24, d);
            if (full || k == 0 || k == f)
                chk("R4 payload word", d, 32'hD000_0000 | 32'(base + 1 + k));
        end
        rd(8'h24, d);
        chk("R5 read past end is zero", d, 32'h0);
        rd(8'h08, d);
        chk("R5 index holds at length", d, 32'(f + 1));
    endtask

    task automatic t_missing(input int addr, input string req);
        logic [31:0] d;
        start_load(addr);
        rd(8'h20, d);
        chk(req, d, 32'h0);
        rd(8'h24, d);
        chk(req, d, 32'h0);
        rd(8'h08, d);
        chk(req, d, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(8'h0C, d); chk("R1 status after reset", d, 32'h0);
        rd(8'h20, d); chk("R1 header after reset", d, 32'h0);
        rd(8'h08, d); chk("R1 index after reset", d, 32'h0);
        rd(8'h04, d); chk("R1 mode after reset", d, 32'h0);
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        wr(8'h04, 32'h1234_ABCD);
        rd(8'h04, d); chk("R9 mode readback", d, 32'h1234_ABCD);
        rd(8'h10, d); chk("R9 unmapped reads zero", d, 32'h0);
    endtask

    task automatic t_index_seek();
        logic [31:0] d;
        start_load(5);
        wr(8'h08, 32'h2);
        rd(8'h24, d); chk("R4 seek index 2", d, 32'hD000_0000 | 32'(4 + 1 + 2));
        rd(8'h24, d); chk("R4 advance after seek", d, 32'hD000_0000 | 32'(4 + 1 + 3));
    endtask

    task automatic t_busy_cmd();
        logic [31:0] d;
        wr(8'h04, 32'(4) << 16);
        wr(8'h00, 32'h40);
        wr(8'h04, 32'(11) << 16);
        wr(8'h00, 32'h40);
        wait_idle();
        rd(8'h20, d);
        chk("R7 second start ignored", d, hdr_val(1, 4));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        clear_mem();
        put_pkt(0, 2, 0);
        put_pkt(4, 4, 1);
        put_pkt(10, 1, 2);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_found(0, 0, 2, 0, 1'b1);
        t_found(3, 0, 2, 0, 1'b1);
        t_found(4, 4, 4, 1, 1'b1);
        t_found(9, 4, 4, 1, 1'b1);
        t_found(12, 10, 1, 2, 1'b1);
        t_index_seek();
        t_missing(13, "R6 address at terminator");
        t_missing(100, "R6 address past terminator");
        t_busy_cmd();
        clear_mem();
        for (int p = 0; p < 11; p++) put_pkt(p * 256, 254, p);
        t_found(2815, 2560, 254, 10, 1'b0);
        t_missing(3000, "R8 walk ends at array end");
        chk("R8 array address in range", 32'(oob), 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule